// File: doc/BRIEF.md
# Bus-addressed twelve-channel code register slave

This block is a receive-only two-wire serial slave that sits beside a bank of twelve 8-bit code registers, for example those that feed a row of D-A converters. A host writes one register per frame: a START, an address byte, a byte that picks the channel, one data byte, and then a STOP. The block oversamples the clock and data wires with a fast system clock. It finds the START and STOP conditions, shifts in the bytes and acknowledges them by pulling the data wire low through an open-drain enable. When the data byte is accepted, it loads the byte into the chosen register.

The address byte is matched against a fixed four-bit prefix (binary 1001, sent first) and against three strap pins. Up to eight copies can therefore share one bus. The channel byte carries a sparse 4-bit code: twelve of its sixteen values pick a register and the other four are accepted but write nothing. Reads are not supported. An address that does not match, or a read request, leaves the slave silent until the next START or STOP.

Top module: `i2c_chan_dac_regs`

## Requirements
- R1: While reset is low, and after it is released, all twelve registers read 0x00 and the pull-down enable `sda_oe_o` is low.
- R2: A frame with a matching address, channel code k (1 to 12) in bits 3..0 of the second byte, and data byte D sent MSB first, leaves D in register k-1. Register j is found at bits 8*j+7..8*j of `dac_code_o`. No other register changes.
- R3: Bits 7..4 of the address byte must be 1001. With any other prefix, no byte is acknowledged and no register changes.
- R4: Address bits 3..1 must equal `cs_i[2:0]`. With any other value, no byte is acknowledged and no register changes.
- R5: If bit 0 of the address byte is 1 (a read), there is no acknowledge and no register changes.
- R6: For each accepted byte, the slave drives `sda_oe_o` high during the ninth SCL high phase. It raises the enable only while SCL is low.
- R7: Bits 7..4 of the channel byte have no effect.
- R8: Channel codes 0, 13, 14 and 15 are acknowledged on all three bytes, but no register changes.
- R9: Bytes sent after the data byte and before STOP are not acknowledged and do not change any register.
- R10: A repeated START at any point drops the frame in progress and begins a new address byte. The dropped frame writes nothing.
- R11: A STOP that arrives before the data byte is acknowledged ends the frame without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock wire level |
| sda_i | input | 1 | Serial data wire level (resolved bus value) |
| cs_i | input | 3 | Strapped address bits compared with address bits 3..1 |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| dac_code_o | output | 96 | Twelve 8-bit register values, channel index j at bits 8*j+7..8*j |

## Verification
The assertions assume the following about the bus inputs. SCL stays low for more than the synchronizer delay after each falling edge. SDA changes only while SCL is low, except at START and STOP. The strap pins hold still for the whole frame. The bench moves SCL in quarter-phases of five system clocks and changes SDA only in the middle of SCL low. It resolves the wire as the AND of its own drive and the slave's release, and it changes the strap pins only between frames. The sweeps cover every strap value with every valid channel code, every wrong address prefix, every ignored channel code, and STOP and repeated START cut into the middle of a frame.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_SKIP
  } rx_state_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_SUB,
    BY_DATA
  } rx_byte_t;
endpackage

// File: rtl/dacreg_pin_sync.sv
module dacreg_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
      prv <= '1;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prv <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/dacreg_frame_rx.sv
module dacreg_frame_rx
  import dacreg_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         SEL_W      = 4,
  parameter int         CS_W       = 3,
  parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_prv,
  input  logic              sda_lvl,
  input  logic              sda_prv,
  input  logic [CS_W-1:0]   cs,
  output logic              ack_oe,
  output logic              wr_stb,
  output logic [SEL_W-1:0]  wr_chan,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BITS = CNT_W'(DATA_W);

  rx_state_t         state_q, state_n;
  rx_byte_t          byte_q, byte_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic [SEL_W-1:0]  chan_q, chan_n;
  logic              ack_q, ack_n;
  logic              stb_q, stb_n;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit;

  assign scl_rise  = scl_lvl & ~scl_prv;
  assign scl_fall  = ~scl_lvl & scl_prv;
  assign start_det = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prv & ~sda_prv & sda_lvl;
  assign addr_hit  = (shreg_q[DATA_W-1 -: 4] == ADDR_PREFIX)
                   && (shreg_q[CS_W:1] == cs) && !shreg_q[0];

  always_comb begin
    state_n = state_q;
    byte_n  = byte_q;
    cnt_n   = cnt_q;
    shreg_n = shreg_q;
    chan_n  = chan_q;
    ack_n   = ack_q;
    stb_n   = 1'b0;
    if (start_det) begin
      state_n = ST_SHIFT;
      byte_n  = BY_ADDR;
      cnt_n   = '0;
      ack_n   = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      ack_n   = 1'b0;
    end else begin
      case (state_q)
        ST_SHIFT: begin
          if (scl_rise && cnt_q < BITS) begin
            shreg_n = {shreg_q[DATA_W-2:0], sda_lvl};
            cnt_n   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BITS) begin
            state_n = ST_ACK;
            ack_n   = 1'b1;
            case (byte_q)
              BY_ADDR: if (!addr_hit) begin
                state_n = ST_SKIP;
                ack_n   = 1'b0;
              end
              BY_SUB:  chan_n = shreg_q[SEL_W-1:0];
              default: stb_n  = 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            ack_n = 1'b0;
            cnt_n = '0;
            case (byte_q)
              BY_ADDR: begin state_n = ST_SHIFT; byte_n = BY_SUB;  end
              BY_SUB:  begin state_n = ST_SHIFT; byte_n = BY_DATA; end
              default: state_n = ST_SKIP;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= BY_ADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      chan_q  <= '0;
      ack_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      byte_q  <= byte_n;
      cnt_q   <= cnt_n;
      shreg_q <= shreg_n;
      chan_q  <= chan_n;
      ack_q   <= ack_n;
      stb_q   <= stb_n;
    end
  end

  assign ack_oe  = ack_q;
  assign wr_stb  = stb_q;
  assign wr_chan = chan_q;
  assign wr_data = shreg_q;

  assert_ack_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !scl_lvl);

  assert_addr_ack_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && byte_q == BY_ADDR) |->
      (shreg_q[DATA_W-1 -: 4] == ADDR_PREFIX && shreg_q[CS_W:1] == cs && !shreg_q[0]));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

// File: rtl/dacreg_latch_bank.sv
module dacreg_latch_bank #(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [SEL_W-1:0]         wr_chan,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] codes
);
  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit[i] = wr_stb && (wr_chan == SEL_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) codes[i*DATA_W +: DATA_W] <= '0;
      else if (hit[i]) codes[i*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_dead_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_chan == '0 || int'(wr_chan) > NUM_CH)) |=> $stable(codes));
endmodule

// File: rtl/i2c_chan_dac_regs.sv
module i2c_chan_dac_regs #(
  parameter int         NUM_CH      = 12,
  parameter int         DATA_W      = 8,
  parameter int         SEL_W       = 4,
  parameter int         CS_W        = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [CS_W-1:0]          cs_i,
  output logic                     sda_oe_o,
  output logic [NUM_CH*DATA_W-1:0] dac_code_o
);
  logic [1:0]        rst_pipe;
  logic              rst_int;
  logic [1:0]        lvl, prv;
  logic              wr_stb;
  logic [SEL_W-1:0]  wr_chan;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  dacreg_pin_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_int), .din({scl_i, sda_i}), .lvl(lvl), .prv(prv)
  );

  dacreg_frame_rx #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .CS_W(CS_W), .ADDR_PREFIX(ADDR_PREFIX)
  ) u_rx (
    .clk(clk), .rst_n(rst_int),
    .scl_lvl(lvl[1]), .scl_prv(prv[1]), .sda_lvl(lvl[0]), .sda_prv(prv[0]),
    .cs(cs_i), .ack_oe(sda_oe_o),
    .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_data(wr_data)
  );

  dacreg_latch_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_int), .wr_stb(wr_stb), .wr_chan(wr_chan),
    .wr_data(wr_data), .codes(dac_code_o)
  );
endmodule

// File: tb/tb_i2c_chan_dac_regs.sv
`timescale 1ns/1ps
module tb_i2c_chan_dac_regs;
  localparam int NCH = 12;
  localparam int Q   = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl, sda_drv;
  logic [2:0]  cs;
  logic        sda_oe;
  logic [95:0] codes;
  logic        sda_line;
  logic [7:0]  exp_q [NCH];
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_chan_dac_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .cs_i(cs),
    .sda_oe_o(sda_oe), .dac_code_o(codes)
  );

  function automatic logic [95:0] model_flat();
    logic [95:0] f;
    for (int j = 0; j < NCH; j++) f[j*8 +: 8] = exp_q[j];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    acked = sda_oe;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                       output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte(a, k); acks[2] = k;
    send_byte(s, k); acks[1] = k;
    send_byte(d, k); acks[0] = k;
    bus_stop();
    wq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic       k;
    logic [7:0] d;
    scl = 1'b1; sda_drv = 1'b1; cs = 3'd0; rst_n = 1'b0;
    for (int j = 0; j < NCH; j++) exp_q[j] = 8'h00;
    repeat (5) @(negedge clk);
    chk(codes == 96'h0 && !sda_oe, "R1 reset state", codes, 96'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(codes == 96'h0 && !sda_oe, "R1 after release", codes, 96'h0);

    // R2 R4 R6: every strap value with every valid channel, plus one wrong strap
    for (int c = 0; c < 8; c++) begin
      cs = 3'(c);
      for (int kc = 1; kc <= NCH; kc++) begin
        d = 8'((c * 53 + kc * 29 + 7) % 256);
        frame({4'b1001, 3'(c), 1'b0}, 8'(kc), d, acks);
        exp_q[kc-1] = d;
        chk(acks == 3'b111, "R6 ack on three bytes", 96'(acks), 96'h7);
        chk(codes == model_flat(), "R2 register write", codes, model_flat());
      end
      frame({4'b1001, 3'((c + 1) % 8), 1'b0}, 8'h01, 8'h5A, acks);
      chk(acks == 3'b000, "R4 strap mismatch no ack", 96'(acks), 96'h0);
      chk(codes == model_flat(), "R4 strap mismatch no write", codes, model_flat());
    end

    // R3: every other prefix
    cs = 3'd5;
    for (int p = 0; p < 16; p++) begin
      if (p == 9) continue;
      frame({4'(p), 3'd5, 1'b0}, 8'h02, 8'hC3, acks);
      chk(acks == 3'b000, "R3 prefix no ack", 96'(acks), 96'h0);
      chk(codes == model_flat(), "R3 prefix no write", codes, model_flat());
    end

    // R5: read request
    frame({4'b1001, 3'd5, 1'b1}, 8'h03, 8'h11, acks);
    chk(acks == 3'b000, "R5 read no ack", 96'(acks), 96'h0);
    chk(codes == model_flat(), "R5 read no write", codes, model_flat());

    // R7: upper nibble of channel byte ignored
    for (int u = 0; u < 16; u++) begin
      d = 8'(u * 17 + 1);
      frame({4'b1001, 3'd5, 1'b0}, {4'(u), 4'd3}, d, acks);
      exp_q[2] = d;
      chk(codes == model_flat() && acks == 3'b111, "R7 upper nibble ignored", codes, model_flat());
    end

    // R2: MSB-first ordering
    frame({4'b1001, 3'd5, 1'b0}, 8'h0C, 8'h80, acks);
    exp_q[11] = 8'h80;
    chk(codes == model_flat(), "R2 MSB first 0x80", codes, model_flat());
    frame({4'b1001, 3'd5, 1'b0}, 8'h0C, 8'h01, acks);
    exp_q[11] = 8'h01;
    chk(codes == model_flat(), "R2 MSB first 0x01", codes, model_flat());

    // R8: codes without a register
    for (int v = 0; v < 16; v++) begin
      if (v >= 1 && v <= NCH) continue;
      frame({4'b1001, 3'd5, 1'b0}, 8'(v), 8'hEE, acks);
      chk(acks == 3'b111, "R8 dead code acked", 96'(acks), 96'h7);
      chk(codes == model_flat(), "R8 dead code no write", codes, model_flat());
    end

    // R9: extra bytes after data
    bus_start();
    send_byte({4'b1001, 3'd5, 1'b0}, k);
    send_byte(8'h04, k);
    send_byte(8'h44, k);
    exp_q[3] = 8'h44;
    send_byte(8'h99, k);
    chk(!k, "R9 extra byte not acked", 96'(k), 96'h0);
    send_byte(8'h05, k);
    chk(!k, "R9 second extra byte not acked", 96'(k), 96'h0);
    bus_stop(); wq();
    chk(codes == model_flat(), "R9 extra bytes no write", codes, model_flat());

    // R10: repeated START mid channel byte, then after channel byte
    bus_start();
    send_byte({4'b1001, 3'd5, 1'b0}, k);
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    bus_start();
    send_byte({4'b1001, 3'd5, 1'b0}, k);
    chk(k, "R10 address after repeated start acked", 96'(k), 96'h1);
    send_byte(8'h05, k);
    bus_start();
    send_byte({4'b1001, 3'd5, 1'b0}, k);
    send_byte(8'h06, k);
    send_byte(8'h66, k);
    exp_q[5] = 8'h66;
    bus_stop(); wq();
    chk(codes == model_flat(), "R10 restarted frame writes only its target", codes, model_flat());

    // R11: STOP before data completes
    bus_start();
    send_byte({4'b1001, 3'd5, 1'b0}, k);
    send_byte(8'h07, k);
    bus_stop(); wq();
    chk(codes == model_flat(), "R11 stop after channel byte no write", codes, model_flat());
    bus_start();
    send_byte({4'b1001, 3'd5, 1'b0}, k);
    send_byte(8'h07, k);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    bus_stop(); wq();
    chk(codes == model_flat(), "R11 stop inside data byte no write", codes, model_flat());
    frame({4'b1001, 3'd5, 1'b0}, 8'h07, 8'h77, acks);
    exp_q[6] = 8'h77;
    chk(codes == model_flat(), "R11 next frame after stop writes", codes, model_flat());

    // R1: reset after activity
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(codes == 96'h0 && !sda_oe, "R1 reset clears registers", codes, 96'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int j = 0; j < NCH; j++) exp_q[j] = 8'h00;
    chk(codes == model_flat(), "R1 cleared after release", codes, model_flat());

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule